// File: doc/BRIEF.md
# Two-Cycle System Bus Master

This block is the bus-facing sequencer of a small CPU core. The core hands it one request at a time: a memory read, a memory write, an I/O read or an I/O write, with an address and, for writes, a data word. The sequencer turns each request into a fixed bus transaction that is exactly two clock cycles long, on a split (tri-state-free) data bus.

In the first cycle, the setup cycle, the address is presented and the read and write strobes stay off, so the target has a whole cycle to decode the address. A write also presents its data and its data-out enable during this cycle. In the second cycle, the strobe cycle, the read or the write strobe is asserted. The memory/I/O select is held for both cycles. A read captures the incoming data bus on the clock edge that ends the strobe cycle. In the following cycle the core sees a one-cycle done pulse together with the captured word. Instruction fetches are issued as ordinary memory reads. The polarity of each strobe is a build-time parameter.

Top module: `sys_bus_master`

## Requirements
- R1: While idle, the master drives the address bus and write-data bus to zero, holds the data-out enable and the I/O select low, keeps busy low and keeps both strobes at their inactive level.
- R2: A request is accepted on a clock edge where the master is idle and the request valid input is high. Busy is then high for exactly the two cycles that follow. The request code has bit 0 = 1 for a write and bit 1 = 1 for an I/O access: 00 memory read, 01 memory write, 10 I/O read, 11 I/O write.
- R3: In the setup cycle, the address is driven and both strobes are inactive. For writes, the write data is also driven with the data-out enable high. For reads, the data-out enable stays low.
- R4: In the strobe cycle, only the strobe that matches the request direction is active, for that one cycle. Address, write data and data-out enable keep their setup-cycle values, and the two strobes are never active together.
- R5: The I/O select is 1 through both cycles of an I/O transaction and 0 through both cycles of a memory transaction.
- R6: A read captures the data-in bus on the edge that ends the strobe cycle and presents it on the read-data output from the next cycle. Read data keeps its value until the next read completes, and writes leave it unchanged.
- R7: Every transaction, read or write, is followed by a done pulse that lasts exactly one cycle, in the first cycle after the strobe cycle.
- R8: A request presented while busy is ignored: it does not alter the running transaction and starts no later one.
- R9: With a strobe's active-high parameter cleared, that strobe is active low: 0 in its strobe cycle and 1 at all other times.
- R10: Asserting the asynchronous reset, even in the middle of a transaction, immediately returns the master to idle with both strobes inactive for the configured polarity and read data cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Core request valid |
| req_op_i | input | 2 | Request code: bit 0 write, bit 1 I/O |
| req_addr_i | input | ADDR_W | Request address |
| req_wdata_i | input | DATA_W | Write data |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Last captured read data |
| bus_addr_o | output | ADDR_W | Address bus |
| bus_wdata_o | output | DATA_W | Data-out bus |
| bus_wdata_en_o | output | 1 | Data-out bus enable |
| bus_rd_o | output | 1 | Read strobe (polarity by parameter) |
| bus_wr_o | output | 1 | Write strobe (polarity by parameter) |
| bus_iom_o | output | 1 | 1 for I/O access, 0 for memory |
| bus_rdata_i | input | DATA_W | Data-in bus |

## Verification
The bench model returns the inverse of the correct data in every cycle except the strobe cycle of a read. A capture one edge early or late therefore yields a wrong word in the scoreboard. A request is held high through a whole transaction with a different code and address. A master that accepted it while busy would disturb the address in the strobe cycle or add a second done pulse. Writes between reads show whether read data is left unchanged. A reset in the middle of a transaction, applied to a copy with active-low strobes, catches a reset state that is written as a literal zero rather than as the inactive level.

// File: rtl/sys_bus_pkg.sv
package sys_bus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2
  } seq_state_e;

  // bit 0: write, bit 1: I/O space
  typedef enum logic [1:0] {
    OP_MEM_RD = 2'b00,
    OP_MEM_WR = 2'b01,
    OP_IO_RD  = 2'b10,
    OP_IO_WR  = 2'b11
  } bus_op_e;

  function automatic logic op_is_write(bus_op_e op);
    return op[0];
  endfunction

  function automatic logic op_is_io(bus_op_e op);
    return op[1];
  endfunction
endpackage

// File: rtl/bus_master_seq.sv
module bus_master_seq
  import sys_bus_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  output seq_state_e state_o,
  output logic       accept_o,
  output logic       last_o
);
  seq_state_e state_q, state_d;

  assign accept_o = req_valid_i && (state_q == ST_IDLE);
  assign last_o   = (state_q == ST_STROBE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_valid_i) state_d = ST_SETUP;
      ST_SETUP:  state_d = ST_STROBE;
      ST_STROBE: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/bus_master_capture.sv
module bus_master_capture
  import sys_bus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              last_i,
  input  bus_op_e           req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output bus_op_e           op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);
  bus_op_e           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_MEM_RD;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      op_q    <= req_op_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
    end
  end

  // sample data-in on the edge closing the strobe cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_i;
      if (last_i && !op_is_write(op_q)) rdata_q <= bus_rdata_i;
    end
  end

  assign op_o    = op_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign rdata_o = rdata_q;
  assign done_o  = done_q;
endmodule

// File: rtl/bus_master_pins.sv
module bus_master_pins
  import sys_bus_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter bit RD_ACT_HIGH = 1'b1,
  parameter bit WR_ACT_HIGH = 1'b1
) (
  input  seq_state_e        state_i,
  input  bus_op_e           op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              bus_wdata_en_o,
  output logic              bus_rd_o,
  output logic              bus_wr_o,
  output logic              bus_iom_o
);
  logic active, rd_on, wr_on, wr_drive;

  assign active   = (state_i != ST_IDLE);
  assign wr_drive = active && op_is_write(op_i);
  assign rd_on    = (state_i == ST_STROBE) && !op_is_write(op_i);
  assign wr_on    = (state_i == ST_STROBE) &&  op_is_write(op_i);

  assign bus_addr_o     = active   ? addr_i  : '0;
  assign bus_wdata_o    = wr_drive ? wdata_i : '0;
  assign bus_wdata_en_o = wr_drive;
  assign bus_iom_o      = active && op_is_io(op_i);

  generate
    if (RD_ACT_HIGH) begin : g_rd_hi
      assign bus_rd_o = rd_on;
    end else begin : g_rd_lo
      assign bus_rd_o = ~rd_on;
    end
    if (WR_ACT_HIGH) begin : g_wr_hi
      assign bus_wr_o = wr_on;
    end else begin : g_wr_lo
      assign bus_wr_o = ~wr_on;
    end
  endgenerate
endmodule

// File: rtl/sys_bus_master.sv
module sys_bus_master
  import sys_bus_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter bit RD_ACT_HIGH = 1'b1,
  parameter bit WR_ACT_HIGH = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              bus_wdata_en_o,
  output logic              bus_rd_o,
  output logic              bus_wr_o,
  output logic              bus_iom_o,
  input  logic [DATA_W-1:0] bus_rdata_i
);
  seq_state_e        state;
  logic              accept, last;
  bus_op_e           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  bus_master_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .state_o    (state),
    .accept_o   (accept),
    .last_o     (last)
  );

  bus_master_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .last_i     (last),
    .req_op_i   (bus_op_e'(req_op_i)),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .bus_rdata_i(bus_rdata_i),
    .op_o       (op_q),
    .addr_o     (addr_q),
    .wdata_o    (wdata_q),
    .rdata_o    (rdata_o),
    .done_o     (done_o)
  );

  bus_master_pins #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .RD_ACT_HIGH(RD_ACT_HIGH), .WR_ACT_HIGH(WR_ACT_HIGH)
  ) u_pins (
    .state_i       (state),
    .op_i          (op_q),
    .addr_i        (addr_q),
    .wdata_i       (wdata_q),
    .bus_addr_o    (bus_addr_o),
    .bus_wdata_o   (bus_wdata_o),
    .bus_wdata_en_o(bus_wdata_en_o),
    .bus_rd_o      (bus_rd_o),
    .bus_wr_o      (bus_wr_o),
    .bus_iom_o     (bus_iom_o)
  );

  assign busy_o = (state != ST_IDLE);
endmodule

// File: rtl/sys_bus_master_chk.sv
module sys_bus_master_chk #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter bit RD_ACT_HIGH = 1'b1,
  parameter bit WR_ACT_HIGH = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_wdata_en_o,
  input logic              bus_rd_o,
  input logic              bus_wr_o,
  input logic              bus_iom_o
);
  logic rd_on, wr_on;
  assign rd_on = (bus_rd_o == RD_ACT_HIGH);
  assign wr_on = (bus_wr_o == WR_ACT_HIGH);

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (bus_addr_o == '0) && !bus_wdata_en_o && !bus_iom_o && !rd_on && !wr_on); // R1
  AST_BUSY_ROSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> busy_o); // R2
  AST_BUSY_TWO_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |=> !busy_o); // R2
  AST_RD_IN_SECOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_on |-> busy_o && $past(busy_o) && $stable(bus_addr_o)); // R4
  AST_WR_IN_SECOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_on |-> busy_o && $past(busy_o) && bus_wdata_en_o); // R4
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_on && wr_on)); // R4
  AST_SETUP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !rd_on && !wr_on); // R3
  AST_IOM_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(bus_iom_o)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_DONE_AFTER_TXN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o)); // R7
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(rdata_o)); // R6
endmodule

bind sys_bus_master sys_bus_master_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .RD_ACT_HIGH(RD_ACT_HIGH), .WR_ACT_HIGH(WR_ACT_HIGH)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .rdata_o       (rdata_o),
  .bus_addr_o    (bus_addr_o),
  .bus_wdata_en_o(bus_wdata_en_o),
  .bus_rd_o      (bus_rd_o),
  .bus_wr_o      (bus_wr_o),
  .bus_iom_o     (bus_iom_o)
);

// File: tb/sys_bus_master_tb.sv
module sys_bus_master_tb;
  localparam int AW = 16;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;

  logic busy, done, wd_en, rd, wr, iom;
  logic [DW-1:0] rdata, wdata, rdata_in;
  logic [AW-1:0] addr;
  logic busy_l, done_l, wd_en_l, rd_l, wr_l, iom_l;
  logic [DW-1:0] rdata_l, wdata_l, rdata_in_l;
  logic [AW-1:0] addr_l;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] last_rd = '0;

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] model(logic [AW-1:0] a, logic io);
    return a[7:0] ^ a[15:8] ^ (io ? 8'h5A : 8'hC3);
  endfunction

  // correct data only in the strobe cycle of a read
  assign rdata_in   = rd          ? model(addr, iom)     : ~model(addr, iom);
  assign rdata_in_l = (rd_l == 0) ? model(addr_l, iom_l) : ~model(addr_l, iom_l);

  sys_bus_master #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .busy_o(busy), .done_o(done),
    .rdata_o(rdata), .bus_addr_o(addr), .bus_wdata_o(wdata), .bus_wdata_en_o(wd_en),
    .bus_rd_o(rd), .bus_wr_o(wr), .bus_iom_o(iom), .bus_rdata_i(rdata_in));

  sys_bus_master #(.ADDR_W(AW), .DATA_W(DW), .RD_ACT_HIGH(1'b0), .WR_ACT_HIGH(1'b0)) u_dut_lo (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .busy_o(busy_l), .done_o(done_l),
    .rdata_o(rdata_l), .bus_addr_o(addr_l), .bus_wdata_o(wdata_l), .bus_wdata_en_o(wd_en_l),
    .bus_rd_o(rd_l), .bus_wr_o(wr_l), .bus_iom_o(iom_l), .bus_rdata_i(rdata_in_l));

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_idle(string req);
    chk(addr == 0 && wdata == 0 && !wd_en && !iom && !busy, req, {addr, wdata, wd_en, iom, busy}, 0);
    chk(rd == 1'b0 && wr == 1'b0, req, {rd, wr}, 2'b00);
    chk(rd_l == 1'b1 && wr_l == 1'b1, {req, " R9"}, {rd_l, wr_l}, 2'b11);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (done) begin
      if (exp_q.size() == 0) chk(0, "R8 spurious done", 1, 0);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        chk(rdata == e, "R6 rdata", rdata, e);
        chk(rdata_l == e, "R6 rdata lo", rdata_l, e);
        chk(done_l == 1'b1, "R7 done lo", done_l, 1);
      end
    end
  end

  task automatic run_txn(logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d, bit hold_busy);
    bit w, io;
    w = op[0];
    io = op[1];
    @(negedge clk);
    req_op = op; req_addr = a; req_wdata = d; req_valid = 1'b1;
    @(negedge clk);  // setup cycle
    if (!w) last_rd = model(a, io);
    exp_q.push_back(last_rd);
    chk(busy && busy_l, "R2 busy setup", busy, 1);
    chk(addr == a && addr_l == a, "R3 addr setup", addr, a);
    chk(rd == 0 && wr == 0 && rd_l == 1 && wr_l == 1, "R3 strobes off", {rd, wr, rd_l, wr_l}, 4'b0011);
    chk(wd_en == w && wdata == (w ? d : '0), "R3 wdata setup", {wd_en, wdata}, {w, (w ? d : 8'h00)});
    chk(iom == io && iom_l == io, "R5 iom setup", iom, io);
    if (hold_busy) begin
      req_op = ~op; req_addr = ~a; req_wdata = ~d;
    end else req_valid = 1'b0;
    @(negedge clk);  // strobe cycle
    chk(busy, "R2 busy strobe", busy, 1);
    chk(rd == !w && wr == w, "R4 strobe", {rd, wr}, {!w, w});
    chk(rd_l == w && wr_l == !w, "R9 strobe lo", {rd_l, wr_l}, {w, !w});
    chk(addr == a && wd_en == w && wdata == (w ? d : '0), "R4 held", {addr, wd_en, wdata}, {a, w, (w ? d : 8'h00)});
    chk(iom == io, "R5 iom strobe", iom, io);
    if (hold_busy) begin
      @(negedge clk);  // done cycle
      req_valid = 1'b0;
      chk(!busy, "R7 idle at done", busy, 0);
      @(negedge clk);
      chk(!busy && !done, "R8 busy request ignored", {busy, done}, 0);
    end else req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    #1;
    chk_idle("R10 reset idle");
    chk(rdata == 0, "R10 rdata reset", rdata, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 idle");

    run_txn(2'b00, 16'h1234, 8'h00, 0);
    run_txn(2'b10, 16'h00FF, 8'h00, 0);
    run_txn(2'b01, 16'hABCD, 8'h5E, 0);  // R6 write leaves rdata
    run_txn(2'b11, 16'h0042, 8'h99, 0);
    run_txn(2'b00, 16'hFFFF, 8'h00, 0);  // back-to-back after done
    run_txn(2'b10, 16'h8001, 8'h00, 1);  // R8
    run_txn(2'b01, 16'h0000, 8'hFF, 1);  // R8
    @(negedge clk);
    @(negedge clk);
    chk(!done, "R7 single pulse", done, 0);
    chk_idle("R1 idle after traffic");

    // R10 mid-transaction reset
    req_op = 2'b00; req_addr = 16'h5555; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);  // strobe cycle
    rst_n = 1'b0;
    #1;
    chk_idle("R10 reset mid-txn");
    chk(rdata == 0 && rdata_l == 0, "R10 rdata cleared", rdata, 0);
    last_rd = '0;
    @(negedge clk);
    chk(!done, "R10 no done after reset", done, 0);
    rst_n = 1'b1;
    run_txn(2'b10, 16'h3C3C, 8'h00, 0);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all done seen", exp_q.size(), 0);
    summary();
  end
endmodule